// File: doc/BRIEF.md
# SPI Configuration Command Port

This block is the target end of a configuration link. An external master drives SPI mode 0 pins (clock idle low, data sampled on the rising clock edge, changed on the falling edge) and sends byte-wide commands framed by an active-low chip select. The port answers two reads: a fixed 32-bit device identifier and a 32-bit status word. It acts on four control commands: clear, refresh, write enable and write disable. It also accepts a bulk incrementing write whose payload bytes are handed to a byte sink and counted.

All SPI pins are resynchronised into the system clock domain. Every command frame starts with an opcode byte followed by three stuffing bytes. A control command takes effect when the fourth byte of its frame completes. A read answers in the four bytes that follow that 4-byte header, most significant bit first. A clear runs for a programmable number of system clocks before the cleared flag rises. Done is latched by write disable when at least one payload byte was taken.

Top module: `cfg_cmd_port`

## Requirements
- R1: After a synchronous reset, cfg_cleared, cfg_done, cfg_valid and spi_miso are 0, cfg_count is 0 and writes are disabled.
- R2: Opcode 0x07 returns DEVICE_ID (default 0xC2088080) on spi_miso during frame bytes 4 to 7, MSB first, whatever the three stuffing bytes hold. spi_miso is 0 during bytes 0 to 3.
- R3: Opcode 0x09 returns the status word in frame bytes 4 to 7, MSB first. Bit 16 is the cleared flag, bit 14 is the done flag and every other bit is 0. The word is captured when byte 3 completes.
- R4: Opcode 0x70 drops cfg_cleared and cfg_done, zeroes cfg_count, and raises cfg_cleared again CLEAR_CYCLES system clocks later. After that the status reply is exactly 0x00010000.
- R5: With writes enabled, opcode 0x41 treats frame bytes 0 to 3 as header and every later byte of the same frame as payload. Each payload byte appears on cfg_data with a one-cycle cfg_valid pulse, in order, and cfg_count increments by one per byte, saturating.
- R6: Opcode 0x4A enables writes. Payload bytes sent while writes are disabled produce no cfg_valid pulse and leave cfg_count unchanged.
- R7: Opcode 0x4F disables writes and sets cfg_done to 1 if cfg_count is nonzero, or to 0 if it is zero. Payload sent afterwards is ignored.
- R8: Raising spi_cs_n ends the frame. A partial byte is dropped, the decoder returns to idle, and a command whose fourth byte did not complete has no effect.
- R9: Opcode 0x71 clears cfg_cleared, cfg_done, cfg_count and the write enable.
- R10: Any other opcode changes no state and returns 0 on spi_miso.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the master, mode 0 |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select, frames commands |
| spi_miso | output | 1 | Serial reply to the master |
| cfg_cleared | output | 1 | Clear has finished |
| cfg_done | output | 1 | Configuration complete |
| cfg_valid | output | 1 | One-cycle strobe for a payload byte |
| cfg_data | output | 8 | Payload byte |
| cfg_count | output | COUNT_W | Payload bytes taken since the last clear or refresh |

## Verification
An SPI edge reaches the byte logic three system clocks after it occurs: two synchroniser stages plus one edge-detect register. A command pulse acts one clock later than that, so cfg_valid, cfg_count and the flags settle within about five clocks of the last rising SCLK edge of a byte. spi_miso changes about three clocks after a falling SCLK edge. The bench holds each SCLK phase for six system clocks. It samples spi_miso just before it raises SCLK, and it checks the flags only after chip select has been high for eight clocks. The clear timing is checked in two places: by a status read issued well inside the CLEAR_CYCLES window, and by a port check taken after that window has clearly ended.

// File: rtl/cfgp_pkg.sv
// Package: opcodes, status bit positions and shared widths of the config port.
// Assumes byte-wide commands; the frame index saturates, so its width only
// has to reach past the reply window (bytes 4..7).
package cfgp_pkg;
    localparam int IDX_W = 4;

    localparam logic [7:0] OP_NONE   = 8'h00;
    localparam logic [7:0] OP_RD_ID  = 8'h07;
    localparam logic [7:0] OP_RD_ST  = 8'h09;
    localparam logic [7:0] OP_CLEAR  = 8'h70;
    localparam logic [7:0] OP_REFR   = 8'h71;
    localparam logic [7:0] OP_WR_EN  = 8'h4A;
    localparam logic [7:0] OP_WR_DIS = 8'h4F;
    localparam logic [7:0] OP_WR_INC = 8'h41;

    localparam int ST_CLEARED_BIT = 16;
    localparam int ST_DONE_BIT    = 14;

    typedef struct packed {
        logic clear;
        logic refresh;
        logic wr_en;
        logic wr_dis;
    } cmd_t;
endpackage

// File: rtl/cfgp_spi_shifter.sv
// SPI mode 0 shifter: synchronises the pins, assembles bytes on rising SCLK
// edges and drives the reply bits on falling edges.
// Assumes each SCLK phase lasts at least four system clocks.
module cfgp_spi_shifter
    import cfgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             mosi,
    input  logic             cs_n,
    input  logic [31:0]      reply,
    input  logic             reply_act,
    output logic             miso,
    output logic             frame_idle,
    output logic             byte_stb,
    output logic [7:0]       byte_val,
    output logic [IDX_W-1:0] byte_idx_o
);
    logic [2:0]       sclk_q;
    logic [1:0]       mosi_q;
    logic [1:0]       cs_q;
    logic [2:0]       bit_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic [6:0]       shreg;
    logic             rise, fall, sel;

    assign rise       = sclk_q[1] & ~sclk_q[2];
    assign fall       = ~sclk_q[1] & sclk_q[2];
    assign sel        = ~cs_q[1];
    assign frame_idle = ~sel;

    // Two-stage synchronisers, with a third SCLK stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            cs_q   <= 2'b11;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            mosi_q <= {mosi_q[0], mosi};
            cs_q   <= {cs_q[0], cs_n};
        end
    end

    // Bit and byte position within the frame; cleared whenever deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
        end else if (rise) begin
            shreg   <= {shreg[5:0], mosi_q[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_idx != '1)
                byte_idx <= byte_idx + 1'b1;
        end
    end

    // Registered strobe carrying a completed byte and its index in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_stb   <= 1'b0;
            byte_val   <= '0;
            byte_idx_o <= '0;
        end else begin
            byte_stb   <= sel & rise & (bit_cnt == 3'd7);
            byte_val   <= {shreg, mosi_q[1]};
            byte_idx_o <= byte_idx;
        end
    end

    // Reply bit for the next rising edge; only bytes 4..7 of an armed read.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel)
            miso <= 1'b0;
        else if (fall)
            miso <= (reply_act && byte_idx[IDX_W-1:2] == 1)
                    ? reply[{~byte_idx[1:0], ~bit_cnt}] : 1'b0;
    end

    p_miso_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        miso |-> reply_act);
endmodule

// File: rtl/cfgp_decoder.sv
// Command decoder: latches the opcode from byte 0, fires control pulses when
// byte 3 completes, arms read replies and forwards payload of bulk writes.
// Assumes the byte strobe is a one-cycle pulse and the index counts bytes.
module cfgp_decoder
    import cfgp_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID = 32'hC208_8080
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_idle,
    input  logic             byte_stb,
    input  logic [7:0]       byte_val,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic             cleared,
    input  logic             done,
    input  logic             wr_open,
    output logic [31:0]      reply,
    output logic             reply_act,
    output cmd_t             cmd,
    output logic             data_vld,
    output logic [7:0]       data_out
);
    logic [7:0]  opcode;
    logic [31:0] st_word;
    logic        at_hdr_end;

    assign at_hdr_end = byte_stb && byte_idx == IDX_W'(3);

    // Status word assembled from the flags; all other bits read 0.
    always_comb begin
        st_word                 = '0;
        st_word[ST_CLEARED_BIT] = cleared;
        st_word[ST_DONE_BIT]    = done;
    end

    // Opcode register, returned to idle whenever the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_idle)
            opcode <= OP_NONE;
        else if (byte_stb && byte_idx == '0)
            opcode <= byte_val;
    end

    // Read reply capture at the end of the 4-byte header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reply     <= '0;
            reply_act <= 1'b0;
        end else if (frame_idle) begin
            reply_act <= 1'b0;
        end else if (at_hdr_end && (opcode == OP_RD_ID || opcode == OP_RD_ST)) begin
            reply_act <= 1'b1;
            reply     <= (opcode == OP_RD_ID) ? DEVICE_ID : st_word;
        end
    end

    // Control pulses, one per completed header.
    always_comb begin
        cmd.clear   = at_hdr_end && opcode == OP_CLEAR;
        cmd.refresh = at_hdr_end && opcode == OP_REFR;
        cmd.wr_en   = at_hdr_end && opcode == OP_WR_EN;
        cmd.wr_dis  = at_hdr_end && opcode == OP_WR_DIS;
    end

    // Payload forwarding for bulk writes while writes are open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_vld <= 1'b0;
            data_out <= '0;
        end else begin
            data_vld <= byte_stb && byte_idx >= IDX_W'(4) && opcode == OP_WR_INC && wr_open;
            if (byte_stb)
                data_out <= byte_val;
        end
    end

    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.clear, cmd.refresh, cmd.wr_en, cmd.wr_dis, data_vld}));
endmodule

// File: rtl/cfgp_state.sv
// Configuration state: clear timer, cleared and done flags, write enable and
// payload byte counter. Assumes CLEAR_CYCLES >= 1.
module cfgp_state
    import cfgp_pkg::*;
#(
    parameter int CLEAR_CYCLES = 100,
    parameter int COUNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_t               cmd,
    input  logic               data_vld,
    output logic               cleared,
    output logic               done,
    output logic               wr_open,
    output logic [COUNT_W-1:0] count
);
    localparam int TMR_W = $clog2(CLEAR_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(CLEAR_CYCLES);

    logic [TMR_W-1:0] timer;

    // Clear timer: loaded by clear, cancelled by refresh, counts down to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                timer <= '0;
        else if (cmd.clear)        timer <= TMR_LOAD;
        else if (cmd.refresh)      timer <= '0;
        else if (timer != '0)      timer <= timer - 1'b1;
    end

    // Cleared flag rises as the timer expires.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.clear || cmd.refresh) cleared <= 1'b0;
        else if (timer == TMR_W'(1))            cleared <= 1'b1;
    end

    // Done flag latched by write disable when payload was taken.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.clear || cmd.refresh) done <= 1'b0;
        else if (cmd.wr_dis)                    done <= (count != '0);
    end

    // Write enable gate.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.refresh || cmd.wr_dis) wr_open <= 1'b0;
        else if (cmd.wr_en)                      wr_open <= 1'b1;
    end

    // Saturating payload counter.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.clear || cmd.refresh) count <= '0;
        else if (data_vld && count != '1)       count <= count + 1'b1;
    end

    p_clear_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (timer != '0) |-> !cleared);
    p_done_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count != '0));
    p_data_needs_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |-> wr_open);
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0));
endmodule

// File: rtl/cfg_cmd_port.sv
// Top of the SPI configuration command port: shifter, decoder and state.
// Assumes SCLK phases of at least four system clocks and mode 0 timing.
module cfg_cmd_port
    import cfgp_pkg::*;
#(
    parameter logic [31:0] DEVICE_ID    = 32'hC208_8080,
    parameter int          CLEAR_CYCLES = 100,
    parameter int          COUNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic               spi_miso,
    output logic               cfg_cleared,
    output logic               cfg_done,
    output logic               cfg_valid,
    output logic [7:0]         cfg_data,
    output logic [COUNT_W-1:0] cfg_count
);
    logic             frame_idle, byte_stb, reply_act, wr_open;
    logic [7:0]       byte_val;
    logic [IDX_W-1:0] byte_idx;
    logic [31:0]      reply;
    cmd_t             cmd;

    cfgp_spi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
        .reply(reply), .reply_act(reply_act), .miso(spi_miso),
        .frame_idle(frame_idle), .byte_stb(byte_stb), .byte_val(byte_val),
        .byte_idx_o(byte_idx)
    );

    cfgp_decoder #(.DEVICE_ID(DEVICE_ID)) u_dec (
        .clk(clk), .rst_n(rst_n), .frame_idle(frame_idle), .byte_stb(byte_stb),
        .byte_val(byte_val), .byte_idx(byte_idx), .cleared(cfg_cleared),
        .done(cfg_done), .wr_open(wr_open), .reply(reply), .reply_act(reply_act),
        .cmd(cmd), .data_vld(cfg_valid), .data_out(cfg_data)
    );

    cfgp_state #(.CLEAR_CYCLES(CLEAR_CYCLES), .COUNT_W(COUNT_W)) u_state (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .data_vld(cfg_valid),
        .cleared(cfg_cleared), .done(cfg_done), .wr_open(wr_open), .count(cfg_count)
    );
endmodule

// File: tb/test_cfg_cmd_port.sv
module test_cfg_cmd_port;
    localparam logic [31:0] ID  = 32'hC208_8080;
    localparam int          CLR = 3000;
    localparam int          H   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic        miso, cleared, done, valid;
    logic [7:0]  data;
    logic [15:0] count;

    int n_chk = 0, n_fail = 0, cap_n = 0, exp_cnt = 0;
    bit finished = 0;
    logic [7:0] cap [0:63];

    always #4 clk = ~clk;

    cfg_cmd_port #(.DEVICE_ID(ID), .CLEAR_CYCLES(CLR), .COUNT_W(16)) i_cfg_cmd_port (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .cfg_cleared(cleared), .cfg_done(done), .cfg_valid(valid),
        .cfg_data(data), .cfg_count(count)
    );

    // Capture the payload sink.
    always @(posedge clk) if (valid && cap_n < 64) begin
        cap[cap_n] <= data;
        cap_n <= cap_n + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int j);
        return 8'((seed * 17 + j * 29 + 3) & 255);
    endfunction

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b >= 8 - nbits; b--) begin
            mosi = tx[b];
            repeat (H) @(negedge clk);
            rx = {rx[6:0], miso};
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // Full frame: opcode, three stuffing bytes, then ndata trailing bytes.
    task automatic frame(input logic [7:0] op, input logic [7:0] stuff, input int ndata,
                         input int seed, output logic [31:0] hdr, output logic [31:0] word);
        logic [7:0] rx;
        hdr = '0; word = '0;
        cs_low();
        xfer(op, 8, rx);    hdr = {hdr[23:0], rx};
        for (int k = 0; k < 3; k++) begin
            xfer(stuff, 8, rx); hdr = {hdr[23:0], rx};
        end
        for (int j = 0; j < ndata; j++) begin
            xfer(pat(seed, j), 8, rx);
            if (j < 4) word = {word[23:0], rx};
        end
        cs_high();
    endtask

    task automatic cmd4(input logic [7:0] op);
        logic [31:0] h, w;
        frame(op, 8'h00, 0, 0, h, w);
    endtask

    task automatic rd(input logic [7:0] op, input logic [7:0] stuff, output logic [31:0] w);
        logic [31:0] h;
        frame(op, stuff, 4, 0, h, w);
        if (op == 8'h07) chk("R2 header bytes quiet", h, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w, h;
        logic [7:0]  rx;
        int base;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 cleared", {31'b0, cleared}, 32'h0);
        chk("R1 done", {31'b0, done}, 32'h0);
        chk("R1 count", {16'b0, count}, 32'h0);
        chk("R1 miso", {31'b0, miso}, 32'h0);

        // R3 status after reset
        rd(8'h09, 8'h00, w);
        chk("R3 status after reset", w, 32'h0);

        // R2 ID with several stuffing patterns
        rd(8'h07, 8'h00, w); chk("R2 id stuff 00", w, ID);
        rd(8'h07, 8'hFF, w); chk("R2 id stuff FF", w, ID);
        rd(8'h07, 8'hA5, w); chk("R2 id stuff A5", w, ID);

        // R10 unknown opcode: no reply, no state change
        frame(8'h55, 8'h00, 4, 1, h, w);
        chk("R10 unknown reply", w, 32'h0);
        rd(8'h09, 8'h00, w);
        chk("R10 status unchanged", w, 32'h0);

        // R6 payload while writes disabled
        frame(8'h41, 8'hFF, 3, 2, h, w);
        chk("R6 count while disabled", {16'b0, count}, 32'h0);
        chk("R6 no sink strobe", cap_n, 0);

        // R4 clear timing and status
        cmd4(8'h70);
        chk("R4 cleared low after clear", {31'b0, cleared}, 32'h0);
        rd(8'h09, 8'h00, w);
        chk("R4 status during clear", w, 32'h0);
        repeat (CLR) @(negedge clk);
        chk("R4 cleared high", {31'b0, cleared}, 32'h1);
        rd(8'h09, 8'h00, w);
        chk("R4 status after clear", w, 32'h0001_0000);

        // R5 bulk writes with several lengths
        cmd4(8'h4A);
        for (int s = 0; s < 4; s++) begin
            int n;
            n = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 5 : 9;
            base = cap_n;
            frame(8'h41, 8'hFF, n, s + 10, h, w);
            exp_cnt += n;
            chk("R5 count", {16'b0, count}, 32'(exp_cnt));
            for (int j = 0; j < n; j++)
                chk("R5 payload byte", {24'b0, cap[base + j]}, {24'b0, pat(s + 10, j)});
        end

        // R7 write disable with data
        cmd4(8'h4F);
        chk("R7 done set", {31'b0, done}, 32'h1);
        rd(8'h09, 8'h00, w);
        chk("R7 status done", w, 32'h0001_4000);
        frame(8'h41, 8'hFF, 4, 20, h, w);
        chk("R7 payload ignored after disable", {16'b0, count}, 32'(exp_cnt));

        // R9 refresh
        cmd4(8'h71);
        chk("R9 cleared", {31'b0, cleared}, 32'h0);
        chk("R9 done", {31'b0, done}, 32'h0);
        chk("R9 count", {16'b0, count}, 32'h0);
        rd(8'h09, 8'h00, w);
        chk("R9 status", w, 32'h0);
        frame(8'h41, 8'hFF, 2, 21, h, w);
        chk("R9 write closed", {16'b0, count}, 32'h0);

        // R7 disable with no payload
        cmd4(8'h4A);
        cmd4(8'h4F);
        chk("R7 done stays 0 without data", {31'b0, done}, 32'h0);

        // R8 aborted write-enable frame has no effect
        cs_low();
        xfer(8'h4A, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 8, rx); xfer(8'h00, 5, rx);
        cs_high();
        frame(8'h41, 8'hFF, 2, 22, h, w);
        chk("R8 aborted enable", {16'b0, count}, 32'h0);

        // R8 partial byte dropped, next frame decodes from idle
        cs_low();
        xfer(8'h07, 3, rx);
        cs_high();
        rd(8'h07, 8'h00, w);
        chk("R8 id after abort", w, ID);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule